// File: doc/BRIEF.md
# Palette DAC Register Interface

This block is a 256-entry colour lookup table that software fills through a small write-only register window and that display logic reads by 8-bit pixel index. Each entry holds an 8-bit red, green and blue component. The bus side exposes a 16-byte window with two live words. The index word selects the entry to be written. The data word accepts one colour component per write, always taken from the top byte of the 32-bit write value.

Successive data writes fill red, then green, then blue. After blue, the entry pointer moves to the next entry, so software can stream any run of entries, or the whole table, after a single index write. The display side has its own registered read port. That port returns the packed 24-bit colour of any entry one clock after the index is presented, and it never affects the write sequence.

Top module: `palette_dac`

## Requirements
- R1: After reset every entry reads as 24'h000000 except entry 255, which reads as 24'hFFFFFF; the write pointer is entry 0 and the next data write goes to red.
- R2: A write (bus_valid=1, bus_write=1) with bus_addr[3:2]=2'b00 loads the write pointer from bus_wdata[31:24] and makes the next data write go to red.
- R3: Writes with bus_addr[3:2]=2'b01 store bus_wdata[31:24] into the pointed entry's red, green and blue components on the first, second and third write respectively; pix_color packs an entry as {red[23:16], green[15:8], blue[7:0]}.
- R4: The blue write advances the write pointer by one modulo 256 (entry 255 is followed by entry 0) and returns the component step to red.
- R5: Writes with bus_addr[3:2]=2'b10 or 2'b11 change neither the table, the pointer nor the component step; bus_addr bits above bit 3 and bits [1:0] are not decoded, and bus_wdata[23:0] is never used.
- R6: bus_rdata is zero for every access, including reads of the live words.
- R7: pix_color shows, one clock edge after pix_index is sampled, the entry at that index as the table stood before that edge; a component written at the same edge appears one edge later.
- R8: Accesses with bus_write=0, or with bus_valid=0, change neither the table, the pointer nor the component step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe for the register window |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address; only bits [3:2] are decoded |
| bus_wdata | input | 32 | Write value; only bits [31:24] are used |
| bus_rdata | output | 32 | Read value, always zero |
| pix_index | input | 8 | Display-side entry index |
| pix_color | output | 24 | Registered {red, green, blue} of the indexed entry |

## Verification
Directed sequences cover three cases. Streaming across several entries and across the 255-to-0 wrap separates correct pointer advance from a pointer that sticks or skips. Reloading the index part-way through a colour shows whether the component step really returns to red. Writes to the reserved words, reads, and idle strobes placed between data writes would shift a red/green/blue assignment if any of them were decoded, which makes them visible at the display port. A constrained-random mix of all access kinds, with aliased upper address bits, is compared entry by entry against a bench model. A write and a display read of the same entry in one cycle separates the required old-value result from a read-through path.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;

    localparam int COMP_W = 8;

    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } comp_step_e;

    typedef enum logic [1:0] {
        WIN_INDEX = 2'd0,
        WIN_DATA  = 2'd1,
        WIN_RSV2  = 2'd2,
        WIN_RSV3  = 2'd3
    } win_word_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

endpackage

// File: rtl/pdac_bus_decode.sv
module pdac_bus_decode
    import palette_dac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              idx_wr,
    output logic              data_wr,
    output logic [COMP_W-1:0] wr_byte,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int LOW_W = DATA_W - COMP_W;

    win_word_e word_sel;
    logic      wr_strobe;
    logic      unused_bits;

    // Window is 16 bytes: only the word-select bits take part in decode
    assign word_sel  = win_word_e'(bus_addr[3:2]);
    assign wr_strobe = bus_valid && bus_write;
    assign wr_byte   = bus_wdata[DATA_W-1 -: COMP_W];
    assign unused_bits = ^{bus_wdata[LOW_W-1:0], bus_addr[ADDR_W-1:4], bus_addr[1:0]};

    always_comb begin
        idx_wr  = 1'b0;
        data_wr = 1'b0;
        if (wr_strobe) begin
            unique case (word_sel)
                WIN_INDEX: idx_wr  = 1'b1;
                WIN_DATA:  data_wr = 1'b1;
                default: ;
            endcase
        end
    end

    // The window is write-only
    assign bus_rdata = '0;

endmodule

// File: rtl/pdac_step_seq.sv
module pdac_step_seq
    import palette_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [COMP_W-1:0] wr_byte,
    output logic              lut_we,
    output logic [IDX_W-1:0]  lut_idx,
    output comp_step_e        lut_sel
);
    typedef struct packed {
        logic [IDX_W-1:0] index;
        comp_step_e       step;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        lut_we  = 1'b0;
        lut_idx = st_q.index;
        lut_sel = st_q.step;
        if (idx_wr) begin
            st_d.index = wr_byte[IDX_W-1:0];
            st_d.step  = STEP_RED;
        end else if (data_wr) begin
            lut_we = 1'b1;
            unique case (st_q.step)
                STEP_RED: st_d.step = STEP_GRN;
                STEP_GRN: st_d.step = STEP_BLU;
                default: begin
                    st_d.step  = STEP_RED;
                    st_d.index = st_q.index + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.index <= '0;
            st_q.step  <= STEP_RED;
        end else begin
            st_q <= st_d;
        end
    end

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (st_q.index == $past(wr_byte[IDX_W-1:0])) && (st_q.step == STEP_RED)); // R2

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && st_q.step == STEP_RED) |=>
            (st_q.step == STEP_GRN) && $stable(st_q.index)); // R3

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && st_q.step == STEP_BLU) |=>
            (st_q.step == STEP_RED) && (st_q.index == $past(st_q.index) + 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !data_wr) |=> $stable(st_q)); // R8

endmodule

// File: rtl/pdac_lut.sv
module pdac_lut
    import palette_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  comp_step_e        wr_sel,
    input  logic [COMP_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output rgb_t              rd_color
);
    localparam int   ENTRIES = 1 << IDX_W;
    localparam rgb_t BLACK   = '0;
    localparam rgb_t WHITE   = '1;

    rgb_t lut_d [ENTRIES];
    rgb_t lut_q [ENTRIES];
    rgb_t rd_d, rd_q;

    always_comb begin
        lut_d = lut_q;
        if (we) begin
            unique case (wr_sel)
                STEP_RED: lut_d[wr_idx].red = wr_byte;
                STEP_GRN: lut_d[wr_idx].grn = wr_byte;
                default:  lut_d[wr_idx].blu = wr_byte;
            endcase
        end
        // Read the pre-write table: a same-cycle write shows one edge later
        rd_d = lut_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lut_q[i] <= (i == ENTRIES - 1) ? WHITE : BLACK;
            end
            rd_q <= BLACK;
        end else begin
            lut_q <= lut_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_color = rd_q;

    AST_RED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_sel == STEP_RED) |=> lut_q[$past(wr_idx)].red == $past(wr_byte)); // R3

    AST_BLU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_sel == STEP_BLU) |=> lut_q[$past(wr_idx)].blu == $past(wr_byte)); // R3

    AST_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_idx == wr_idx) |=> rd_color == $past(lut_q[rd_idx])); // R7

endmodule

// File: rtl/palette_dac.sv
module palette_dac
    import palette_dac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    pix_index,
    output logic [3*COMP_W-1:0] pix_color
);
    logic              idx_wr;
    logic              data_wr;
    logic [COMP_W-1:0] wr_byte;
    logic              lut_we;
    logic [IDX_W-1:0]  lut_idx;
    comp_step_e        lut_sel;
    rgb_t              rd_color;

    pdac_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .idx_wr    (idx_wr),
        .data_wr   (data_wr),
        .wr_byte   (wr_byte),
        .bus_rdata (bus_rdata)
    );

    pdac_step_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wr_byte (wr_byte),
        .lut_we  (lut_we),
        .lut_idx (lut_idx),
        .lut_sel (lut_sel)
    );

    pdac_lut #(
        .IDX_W (IDX_W)
    ) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (lut_we),
        .wr_idx   (lut_idx),
        .wr_sel   (lut_sel),
        .wr_byte  (wr_byte),
        .rd_idx   (pix_index),
        .rd_color (rd_color)
    );

    assign pix_color = rd_color;

    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr[3]) |-> !lut_we); // R5

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || !bus_write) |-> !lut_we); // R8

endmodule

// File: tb/palette_dac_tb.sv
module palette_dac_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_color;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    logic [7:0] m_idx;
    int         m_step;

    always #10 clk = ~clk;

    palette_dac u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_index (pix_index),
        .pix_color (pix_color)
    );

    function automatic logic [23:0] exp_color(input logic [7:0] i);
        return {mr[i], mg[i], mb[i]};
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) begin
            mr[i] = (i == 255) ? 8'hFF : 8'h00;
            mg[i] = (i == 255) ? 8'hFF : 8'h00;
            mb[i] = (i == 255) ? 8'hFF : 8'h00;
        end
        m_idx  = '0;
        m_step = 0;
    endfunction

    function automatic void model_access(input bit v, input bit w,
                                         input logic [7:0] a, input logic [31:0] d);
        if (!(v && w)) return;
        case (a[3:2])
            2'b00: begin m_idx = d[31:24]; m_step = 0; end
            2'b01: begin
                case (m_step)
                    0: mr[m_idx] = d[31:24];
                    1: mg[m_idx] = d[31:24];
                    default: mb[m_idx] = d[31:24];
                endcase
                if (m_step == 2) begin m_step = 0; m_idx = m_idx + 8'd1; end
                else m_step = m_step + 1;
            end
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access, driven at a falling edge and completed by the next rising edge
    task automatic access(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        model_access(v, w, a, d);
        #1;
        if (v) check("R6 rdata", bus_rdata, 32'h0);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, 1'b1, a, d);
    endtask

    task automatic check_entry(input string req, input logic [7:0] i);
        @(negedge clk);
        pix_index = i;
        @(negedge clk);
        check(req, {8'h0, pix_color}, {8'h0, exp_color(i)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_tmp;
        seed_tmp = $urandom(32'h0C0FFEE5);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, every entry
        for (int i = 0; i < 256; i++) check_entry("R1 reset entry", 8'(i));
        // R1: pointer at 0, step red
        wr(8'h04, 32'h11_000000);
        check_entry("R1 reset pointer red", 8'h00);

        // R2/R3: load index 10, write one colour
        wr(8'h00, 32'h0A_FFFFFF);
        wr(8'h04, 32'h12_000000);
        check_entry("R3 red only", 8'h0A);
        wr(8'h04, 32'h34_ABCDEF);
        wr(8'h04, 32'h56_000000);
        check_entry("R3 full colour", 8'h0A);
        // R4: pointer advanced to 11
        wr(8'h04, 32'h77_000000);
        check_entry("R4 next entry red", 8'h0B);

        // R2: reload mid-colour restarts at red
        wr(8'h00, 32'h20_000000);
        wr(8'h04, 32'hA1_000000);
        wr(8'h00, 32'h21_000000);
        wr(8'h04, 32'hB1_000000);
        check_entry("R2 reload entry 0x20", 8'h20);
        check_entry("R2 reload entry 0x21", 8'h21);

        // R4: wrap 255 -> 0
        wr(8'h00, 32'hFF_000000);
        wr(8'h04, 32'h01_000000);
        wr(8'h04, 32'h02_000000);
        wr(8'h04, 32'h03_000000);
        wr(8'h04, 32'h44_000000);
        check_entry("R4 entry 255", 8'hFF);
        check_entry("R4 wrap to entry 0", 8'h00);

        // R5/R8: reserved words, reads, idle strobes do not disturb the sequence
        wr(8'h00, 32'h40_000000);
        wr(8'h04, 32'h10_000000);
        wr(8'h08, 32'h99_000000);
        wr(8'h0C, 32'h98_000000);
        access(1'b1, 1'b0, 8'h04, 32'h97_000000);
        access(1'b1, 1'b0, 8'h00, 32'h96_000000);
        access(1'b0, 1'b1, 8'h04, 32'h95_000000);
        wr(8'h04, 32'h20_000000);
        wr(8'h04, 32'h30_000000);
        check_entry("R5 R8 sequence intact", 8'h40);
        check_entry("R5 R8 pointer advanced once", 8'h41);

        // R5: upper and low address bits alias
        wr(8'hF3, 32'h50_000000);
        wr(8'hA5, 32'h61_000000);
        wr(8'h16, 32'h62_000000);
        wr(8'hE7, 32'h63_000000);
        check_entry("R5 alias decode", 8'h50);

        // R7: write and read of the same entry in one cycle
        wr(8'h00, 32'h60_000000);
        @(negedge clk);
        pix_index = 8'h60;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hC3_000000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R7 same-cycle old value", {8'h0, pix_color}, {8'h0, exp_color(8'h60)});
        model_access(1'b1, 1'b1, 8'h04, 32'hC3_000000);
        @(negedge clk);
        check("R7 new value next edge", {8'h0, pix_color}, {8'h0, exp_color(8'h60)});

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0]  a;
            logic [31:0] d;
            op = int'($urandom % 16);
            d  = $urandom;
            a  = 8'($urandom);
            if (op < 2)       a[3:2] = 2'b00;
            else if (op < 11) a[3:2] = 2'b01;
            if (op == 11)      access(1'b1, 1'b0, a, d);
            else if (op == 12) access(1'b0, 1'($urandom), a, d);
            else               wr(a, d);
            if (n % 10 == 0) check_entry("R3 R4 random entry", m_idx);
        end

        // Final sweep of the whole table
        for (int i = 0; i < 256; i++) check_entry("R3 final entry", 8'(i));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule